// File: doc/BRIEF.md
# Relocation and Limit Protection Unit

This block sits on the path between a processor and its memory. It guards and relocates the addresses used in a scheme where each user process lives in one contiguous region. Every access made in user mode is checked against a limit register. A legal access has a relocation base added to it. An access that falls outside the region raises a trap to the kernel and never reaches memory. Accesses made in privileged mode pass through unchanged and unchecked.

The base and limit registers are loaded through a small configuration write port that carries its own privilege flag. A write attempted without privilege changes nothing and produces a one-cycle privilege-error pulse. The compare and the add happen in the same cycle, and the result is registered, so every output appears exactly one clock after its request. The trap is sticky. It holds the logical address that caused it until the kernel acknowledges it.

Top module: `reloc_guard`

## Requirements
- R1: After reset, mem_vld, trap and priv_err are 0, and both base and limit are 0. A user access to any address, including address 0, therefore traps.
- R2: A user access (req_vld=1, req_priv=0) whose address is strictly below the limit gives mem_vld=1 one cycle later, with mem_addr = base + zero-extended address modulo 2^PA_W.
- R3: A user access whose address is greater than or equal to the limit gives mem_vld=0 one cycle later, sets trap, and loads trap_addr with the offending logical address.
- R4: A privileged access (req_priv=1) gives mem_vld=1 one cycle later, with mem_addr equal to the zero-extended logical address, whatever the limit is.
- R5: A configuration write with cfg_we=1 and cfg_priv=1 loads base when cfg_sel=0, or loads limit from cfg_data[LA_W:0] when cfg_sel=1. An access in the same cycle still uses the old value, and an access one cycle later uses the new one.
- R6: A configuration write with cfg_priv=0 leaves base and limit unchanged and pulses priv_err high for exactly one cycle, one cycle later. A privileged write leaves priv_err low.
- R7: Once set, trap stays high until trap_ack is sampled high. Further faults while it is held do not change trap_addr.
- R8: A fault in the same cycle as trap_ack keeps trap high and loads trap_addr with the new address. trap_ack alone clears trap one cycle later.
- R9: A limit of 2^LA_W makes every logical address legal.
- R10: A cycle with req_vld=0 gives mem_vld=0 one cycle later and does not set trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Access request strobe |
| req_addr | input | LA_W | Logical address of the access |
| req_priv | input | 1 | 1 = access made in privileged mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | 1 = configuration write made in privileged mode |
| cfg_sel | input | 1 | 0 selects base, 1 selects limit |
| cfg_data | input | PA_W | Value to load |
| trap_ack | input | 1 | Kernel acknowledgement that clears the trap |
| mem_vld | output | 1 | Registered strobe: access forwarded to memory |
| mem_addr | output | PA_W | Registered physical address |
| trap | output | 1 | Sticky protection-fault trap |
| trap_addr | output | LA_W | Logical address that raised the trap |
| priv_err | output | 1 | One-cycle pulse after an unprivileged configuration write |

## Verification
A corrupted base register shows up as a wrong mem_addr on the very next legal user access, one cycle after that access. A corrupted limit shows up as a mismatch between trap and mem_vld at the boundary address, also one cycle later. For this reason the bench sweeps every logical address against several base and limit pairs, including a base that makes the sum wrap. A trap register that loses its hold or reloads its address at the wrong time is caught by issuing back-to-back faults with and without an acknowledge and comparing trap_addr on the following cycle.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_LIMIT = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
  import reloc_pkg::*;
#(
  parameter int LA_W = 16,
  parameter int PA_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic            cfg_priv,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_data,
  output logic [PA_W-1:0] base_q,
  output logic [LA_W:0]   limit_q,
  output logic            priv_err
);
  logic wr_ok;
  logic wr_bad;

  assign wr_ok  = cfg_we && cfg_priv;
  assign wr_bad = cfg_we && !cfg_priv;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      limit_q  <= '0;
      priv_err <= 1'b0;
    end else begin
      priv_err <= wr_bad;
      if (wr_ok) begin
        if (cfg_sel_e'(cfg_sel) == SEL_BASE) base_q  <= cfg_data;
        else                                 limit_q <= cfg_data[LA_W:0];
      end
    end
  end
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
  parameter int LA_W = 16,
  parameter int PA_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_vld,
  input  logic [LA_W-1:0] req_addr,
  input  logic            req_priv,
  input  logic [PA_W-1:0] base_q,
  input  logic [LA_W:0]   limit_q,
  output logic            mem_vld,
  output logic [PA_W-1:0] mem_addr,
  output logic            fault_now
);
  localparam int PAD = PA_W - LA_W;

  logic [PA_W-1:0] addr_zx;
  logic [PA_W-1:0] addr_sum;
  logic            in_range;
  logic            pass;

  assign addr_zx   = {{PAD{1'b0}}, req_addr};
  assign addr_sum  = base_q + addr_zx;
  assign in_range  = ({1'b0, req_addr} < limit_q);
  assign pass      = req_vld && (req_priv || in_range);
  assign fault_now = req_vld && !req_priv && !in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_vld  <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_vld <= pass;
      if (pass) mem_addr <= req_priv ? addr_zx : addr_sum;
    end
  end
endmodule

// File: rtl/reloc_trap.sv
module reloc_trap #(
  parameter int LA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fault_now,
  input  logic [LA_W-1:0] fault_addr,
  input  logic            trap_ack,
  output logic            trap,
  output logic [LA_W-1:0] trap_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trap      <= 1'b0;
      trap_addr <= '0;
    end else if (fault_now) begin
      trap <= 1'b1;
      if (!trap || trap_ack) trap_addr <= fault_addr;
    end else if (trap_ack) begin
      trap <= 1'b0;
    end
  end
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard #(
  parameter int LA_W = 16,
  parameter int PA_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_vld,
  input  logic [LA_W-1:0] req_addr,
  input  logic            req_priv,
  input  logic            cfg_we,
  input  logic            cfg_priv,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_data,
  input  logic            trap_ack,
  output logic            mem_vld,
  output logic [PA_W-1:0] mem_addr,
  output logic            trap,
  output logic [LA_W-1:0] trap_addr,
  output logic            priv_err
);
  logic [PA_W-1:0] base_q;
  logic [LA_W:0]   limit_q;
  logic            fault_now;

  reloc_regs #(.LA_W(LA_W), .PA_W(PA_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .base_q(base_q),
    .limit_q(limit_q), .priv_err(priv_err)
  );

  reloc_xlate #(.LA_W(LA_W), .PA_W(PA_W)) u_xlate (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr),
    .req_priv(req_priv), .base_q(base_q), .limit_q(limit_q),
    .mem_vld(mem_vld), .mem_addr(mem_addr), .fault_now(fault_now)
  );

  reloc_trap #(.LA_W(LA_W)) u_trap (
    .clk(clk), .rst(rst), .fault_now(fault_now), .fault_addr(req_addr),
    .trap_ack(trap_ack), .trap(trap), .trap_addr(trap_addr)
  );
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
  parameter int LA_W = 16,
  parameter int PA_W = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            req_vld,
  input logic [LA_W-1:0] req_addr,
  input logic            req_priv,
  input logic            cfg_we,
  input logic            cfg_priv,
  input logic            cfg_sel,
  input logic [PA_W-1:0] cfg_data,
  input logic            trap_ack,
  input logic            mem_vld,
  input logic [PA_W-1:0] mem_addr,
  input logic            trap,
  input logic [LA_W-1:0] trap_addr,
  input logic            priv_err,
  input logic [PA_W-1:0] base_q,
  input logic [LA_W:0]   limit_q
);
  localparam int PAD = PA_W - LA_W;
  logic [PA_W-1:0] zx;
  logic            user_req;
  logic            below;
  assign zx       = {{PAD{1'b0}}, req_addr};
  assign user_req = req_vld && !req_priv;
  assign below    = {1'b0, req_addr} < limit_q;

  // R2
  a_r2_legal_relocated: assert property (@(posedge clk) disable iff (rst)
    (user_req && below) |=> (mem_vld && mem_addr == $past(base_q + zx)));
  // R3
  a_r3_illegal_trapped: assert property (@(posedge clk) disable iff (rst)
    (user_req && !below) |=> (!mem_vld && trap));
  // R4
  a_r4_priv_passthru: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_priv) |=> (mem_vld && mem_addr == $past(zx)));
  // R5
  a_r5_limit_load: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_priv && cfg_sel) |=> (limit_q == $past(cfg_data[LA_W:0])));
  // R6
  a_r6_user_cfg_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_priv) |=> (priv_err && $stable(base_q) && $stable(limit_q)));
  // R7
  a_r7_trap_held: assert property (@(posedge clk) disable iff (rst)
    (trap && !trap_ack) |=> (trap && $stable(trap_addr)));
  // R10
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !mem_vld);
endmodule

bind reloc_guard reloc_guard_chk #(.LA_W(LA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr),
  .req_priv(req_priv), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
  .cfg_sel(cfg_sel), .cfg_data(cfg_data), .trap_ack(trap_ack),
  .mem_vld(mem_vld), .mem_addr(mem_addr), .trap(trap),
  .trap_addr(trap_addr), .priv_err(priv_err), .base_q(base_q),
  .limit_q(limit_q)
);

// File: tb/sim_reloc_guard.sv
module sim_reloc_guard;
  localparam int LA_W = 4;
  localparam int PA_W = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_vld = 1'b0;
  logic [LA_W-1:0] req_addr = '0;
  logic            req_priv = 1'b0;
  logic            cfg_we = 1'b0;
  logic            cfg_priv = 1'b0;
  logic            cfg_sel = 1'b0;
  logic [PA_W-1:0] cfg_data = '0;
  logic            trap_ack = 1'b0;
  logic            mem_vld;
  logic [PA_W-1:0] mem_addr;
  logic            trap;
  logic [LA_W-1:0] trap_addr;
  logic            priv_err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  reloc_guard #(.LA_W(LA_W), .PA_W(PA_W)) u0 (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr),
    .req_priv(req_priv), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .trap_ack(trap_ack),
    .mem_vld(mem_vld), .mem_addr(mem_addr), .trap(trap),
    .trap_addr(trap_addr), .priv_err(priv_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic priv, input logic sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = priv; cfg_sel = sel; cfg_data = PA_W'(val);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic priv, input int a);
    @(negedge clk);
    req_vld = 1'b1; req_priv = priv; req_addr = LA_W'(a);
    @(posedge clk); #1;
    req_vld = 1'b0;
  endtask

  task automatic ack_trap();
    @(negedge clk);
    trap_ack = 1'b1;
    @(posedge clk); #1;
    trap_ack = 1'b0;
  endtask

  task automatic sweep(input int base, input int lim);
    cfg_wr(1'b1, 1'b0, base);
    cfg_wr(1'b1, 1'b1, lim);
    for (int a = 0; a < (1 << LA_W); a++) begin
      access(1'b0, a);
      if (a < lim) begin
        chk("R2 vld", int'(mem_vld), 1);
        chk("R2 addr", int'(mem_addr), (base + a) % (1 << PA_W));
        chk("R2 notrap", int'(trap), 0);
      end else begin
        chk("R3 novld", int'(mem_vld), 0);
        chk("R3 trap", int'(trap), 1);
        chk("R3 trap_addr", int'(trap_addr), a);
        ack_trap();
        chk("R8 ack clears", int'(trap), 0);
      end
      access(1'b1, a);
      chk("R4 vld", int'(mem_vld), 1);
      chk("R4 addr", int'(mem_addr), a);
      chk("R4 notrap", int'(trap), 0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1 mem_vld", int'(mem_vld), 0);
    chk("R1 trap", int'(trap), 0);
    chk("R1 priv_err", int'(priv_err), 0);
    access(1'b0, 0);
    chk("R1 limit zero traps", int'(trap), 1);
    chk("R1 no forward", int'(mem_vld), 0);
    ack_trap();

    // R10 idle cycle
    @(posedge clk); #1;
    chk("R10 idle", int'(mem_vld), 0);
    chk("R10 no trap", int'(trap), 0);

    sweep(8'h20, 5);
    sweep(8'hF3, 16);   // R9 full range, wrap of the sum
    sweep(8'h40, 1);
    sweep(8'h00, 0);

    // R5 same-cycle write uses old base, next cycle new
    cfg_wr(1'b1, 1'b0, 8'h10);
    cfg_wr(1'b1, 1'b1, 8);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = 1'b1; cfg_sel = 1'b0; cfg_data = 8'h30;
    req_vld = 1'b1; req_priv = 1'b0; req_addr = 4'd2;
    @(posedge clk); #1;
    cfg_we = 1'b0; req_vld = 1'b0;
    chk("R5 old base", int'(mem_addr), 8'h12);
    chk("R6 priv write no err", int'(priv_err), 0);
    access(1'b0, 2);
    chk("R5 new base", int'(mem_addr), 8'h32);

    // R6 unprivileged writes ignored
    cfg_wr(1'b0, 1'b0, 8'h77);
    chk("R6 err pulse", int'(priv_err), 1);
    @(posedge clk); #1;
    chk("R6 err one cycle", int'(priv_err), 0);
    cfg_wr(1'b0, 1'b1, 2);
    chk("R6 err pulse limit", int'(priv_err), 1);
    access(1'b0, 7);
    chk("R6 base kept", int'(mem_addr), 8'h37);
    chk("R6 limit kept", int'(mem_vld), 1);

    // R7 sticky trap keeps first address
    access(1'b0, 9);
    chk("R7 trap", int'(trap), 1);
    access(1'b0, 12);
    chk("R7 still trap", int'(trap), 1);
    chk("R7 first addr kept", int'(trap_addr), 9);
    @(posedge clk); #1;
    chk("R7 held idle", int'(trap), 1);

    // R8 fault with ack loads new address
    @(negedge clk);
    trap_ack = 1'b1; req_vld = 1'b1; req_priv = 1'b0; req_addr = 4'd14;
    @(posedge clk); #1;
    trap_ack = 1'b0; req_vld = 1'b0;
    chk("R8 trap stays", int'(trap), 1);
    chk("R8 new addr", int'(trap_addr), 14);
    ack_trap();
    chk("R8 cleared", int'(trap), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule